// File: doc/BRIEF.md
# Logarithmic-Domain Incremental PI Controller Core

This core runs one step of an incremental PI control law each time a sample strobe arrives (nominally once per millisecond). The control error comes in already in logarithmic form: a sign bit, a two's-complement base-2 logarithm with integer and fractional bits, and a flag that marks the error as exactly zero, which has no finite logarithm. Both gain multiplications are done as additions of fixed base-2 logarithms of the gain constants (about 0.0132 for the present-error gain and 0.0130 for the previous-error gain). Each product is then turned back into a signed fixed-point term by a computed 2^f mantissa table followed by a shift set by the integer exponent.

The two terms update an accumulator as u(k) = u(k-1) + q0·e(k) − q1·e(k−1). The accumulator is clamped to the duty range, and its integer part drives a 12-bit duty command. The core keeps the previous error, including its zero flag, on its own. A zero-flagged operand contributes nothing to its product path. The first zero sample still subtracts the pending delayed term. A second consecutive zero sample leaves the output frozen.

Top module: `log_pi_core`

## Requirements
- R1: While reset is applied, and until the first update after it, `duty` is 0 and `out_valid` is 0. The internal previous error starts out flagged as zero.
- R2: A `sample_tick` sampled high at clock edge k produces an `out_valid` pulse one cycle wide, high after edge k+2. `out_valid` is never high at any other time. Ticks may come on consecutive cycles.
- R3: `err_log` is a signed 12-bit value in units of 1/64 (6 fraction bits), and `err_neg` = 1 marks a negative error. A product logarithm is the sum P = err_log + G, where G is the gain logarithm: −400 for q0 and −401 for q1. With E = floor(P/64) and f = P mod 64, the term magnitude is M = round(4096·2^(f/64)), shifted left by E−4 when E−4 ≥ 0 and right (truncating) otherwise. The shift never exceeds 20. The sign of the term is err_neg XOR the gain sign (both gains positive by default).
- R4: The accumulator has 8 fraction bits. On each update it adds the present-error term and subtracts the previous-error term. `duty` is the accumulator shifted right by 8, and `duty` changes only together with `out_valid`.
- R5: An update whose result is below zero sets the accumulator, and so `duty`, to 0.
- R6: An update whose result exceeds the top of the range sets the accumulator to 4096·256 − 1, so `duty` reads 4095.
- R7: When `err_zero` = 1 on a tick, the present-error term is zero. The previous-error term from the prior sample is still subtracted.
- R8: When `err_zero` = 1 on a tick and the previous sample was also zero-flagged, the update leaves `duty` unchanged.
- R9: Each tick stores its error (sign, logarithm and zero flag) as the previous error for the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sample_tick | input | 1 | One-cycle strobe that starts an update |
| err_neg | input | 1 | Sign of the error, 1 = negative |
| err_log | input | 12 | Signed base-2 logarithm of the error magnitude, 6 fraction bits |
| err_zero | input | 1 | Error is exactly zero; `err_log` and `err_neg` are ignored |
| duty | output | 12 | Saturated duty command |
| out_valid | output | 1 | Pulses when `duty` takes a new update result |

## Verification
Every result is due two edges after the edge that samples the tick. Both the updated `duty` and the `out_valid` pulse appear together after edge k+2. The bench's reference model records each tick at the sampling edge, computes the new accumulator value there from integer and real arithmetic, and queues it with a due edge of k+2. It compares `duty` and `out_valid` at every falling edge, so each output is read half a cycle after it settles. Directed cases wait three falling edges after the tick before they compare hand-computed values: a unit product, the delayed-term subtraction on a first zero sample, holding on a second zero sample, and clamping at both ends.

// File: rtl/lpi_pkg.sv
package lpi_pkg;
  // Per-operand tag carried alongside a logarithm through the pipeline
  typedef struct packed {
    logic neg;
    logic zero;
  } lpi_tag_t;
endpackage

// File: rtl/lpi_log_mul.sv
module lpi_log_mul
  import lpi_pkg::*;
#(
  parameter int LW       = 12,
  parameter int GAIN_LOG = -400,
  parameter bit GAIN_NEG = 1'b0
) (
  input  logic signed [LW-1:0] op_log,
  input  lpi_tag_t             op_tag,
  output logic signed [LW:0]   prod_log,
  output lpi_tag_t             prod_tag
);
  localparam logic signed [LW:0] GAIN_L = (LW+1)'(GAIN_LOG);

  // Multiplication in the log domain: add the logarithms, XOR the signs
  always_comb begin
    prod_log      = $signed({op_log[LW-1], op_log}) + GAIN_L;
    prod_tag.neg  = op_tag.neg ^ GAIN_NEG;
    prod_tag.zero = op_tag.zero;
  end
endmodule

// File: rtl/lpi_antilog.sv
module lpi_antilog
  import lpi_pkg::*;
#(
  parameter int PW        = 13,
  parameter int FRAC_W    = 6,
  parameter int MANT_W    = 12,
  parameter int ACC_FRAC  = 8,
  parameter int SHIFT_CAP = 20,
  parameter int TW        = 34
) (
  input  logic signed [PW-1:0] prod_log,
  input  lpi_tag_t             prod_tag,
  output logic signed [TW-1:0] term
);
  localparam int TBL_N  = 1 << FRAC_W;
  localparam int SH_OFF = MANT_W - ACC_FRAC;

  logic [MANT_W:0] mant_tbl [TBL_N];

  // 2^(i/TBL_N) scaled by 2^MANT_W, computed at elaboration
  for (genvar gi = 0; gi < TBL_N; gi++) begin : g_tbl
    localparam int ENT = int'($pow(2.0, real'(gi) / real'(TBL_N)) * real'(2 ** MANT_W));
    assign mant_tbl[gi] = (MANT_W+1)'(ENT);
  end

  logic signed [PW-FRAC_W-1:0] expo;
  logic [FRAC_W-1:0]           frac;
  logic [TW-1:0]               mant_x;
  logic [TW-1:0]               mag;
  int                          sh;

  always_comb begin
    expo   = prod_log[PW-1:FRAC_W];
    frac   = prod_log[FRAC_W-1:0];
    mant_x = TW'(mant_tbl[frac]);
    sh     = int'(expo) - SH_OFF;
    if (sh >= SHIFT_CAP)  mag = mant_x << SHIFT_CAP;
    else if (sh >= 0)     mag = mant_x << sh;
    else                  mag = mant_x >> (-sh);
    if (prod_tag.zero)    term = '0;
    else if (prod_tag.neg) term = -$signed(mag);
    else                  term = $signed(mag);
  end
endmodule

// File: rtl/lpi_accum.sv
module lpi_accum #(
  parameter int TW       = 34,
  parameter int ACC_FRAC = 8,
  parameter int DUTY_W   = 12
) (
  input  logic                 clk,
  input  logic                 rst_q_n,
  input  logic                 upd_en,
  input  logic                 hold,
  input  logic signed [TW-1:0] t_new,
  input  logic signed [TW-1:0] t_old,
  output logic [DUTY_W-1:0]    duty,
  output logic                 out_valid
);
  localparam int AW = TW + 2;
  localparam logic signed [AW-1:0] TOP_FX = AW'((64'd1 << (DUTY_W + ACC_FRAC)) - 64'd1);

  logic signed [AW-1:0] acc_q, acc_d, sum;
  logic                 vld_q;

  always_comb begin
    sum   = acc_q + AW'(t_new) - AW'(t_old);
    acc_d = acc_q;
    if (!hold) begin
      if (sum < 0)           acc_d = '0;
      else if (sum > TOP_FX) acc_d = TOP_FX;
      else                   acc_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      acc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= upd_en;
      if (upd_en) acc_q <= acc_d;
    end
  end

  assign duty      = acc_q[ACC_FRAC +: DUTY_W];
  assign out_valid = vld_q;
endmodule

// File: rtl/log_pi_core.sv
module log_pi_core
  import lpi_pkg::*;
#(
  parameter int EXP_W     = 6,
  parameter int FRAC_W    = 6,
  parameter int MANT_W    = 12,
  parameter int ACC_FRAC  = 8,
  parameter int DUTY_W    = 12,
  parameter int SHIFT_CAP = 20,
  parameter int LOG_Q0    = -400,
  parameter int LOG_Q1    = -401,
  parameter bit Q0_NEG    = 1'b0,
  parameter bit Q1_NEG    = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_tick,
  input  logic                     err_neg,
  input  logic [EXP_W+FRAC_W-1:0]  err_log,
  input  logic                     err_zero,
  output logic [DUTY_W-1:0]        duty,
  output logic                     out_valid
);
  localparam int LW = EXP_W + FRAC_W;
  localparam int PW = LW + 1;
  localparam int TW = MANT_W + 1 + SHIFT_CAP + 1;

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q_n  <= rst_meta;
    end
  end

  // Previous-error store
  logic signed [LW-1:0] prev_log_q;
  lpi_tag_t             prev_tag_q, cur_tag;

  // Log-domain products
  logic signed [PW-1:0] p_new, p_old;
  lpi_tag_t             tg_new, tg_old;

  assign cur_tag = '{neg: err_neg, zero: err_zero};

  lpi_log_mul #(.LW(LW), .GAIN_LOG(LOG_Q0), .GAIN_NEG(Q0_NEG)) u_mul_new (
    .op_log(err_log), .op_tag(cur_tag), .prod_log(p_new), .prod_tag(tg_new));
  lpi_log_mul #(.LW(LW), .GAIN_LOG(LOG_Q1), .GAIN_NEG(Q1_NEG)) u_mul_old (
    .op_log(prev_log_q), .op_tag(prev_tag_q), .prod_log(p_old), .prod_tag(tg_old));

  // Stage 1 registers
  logic signed [PW-1:0] s1_p_new, s1_p_old;
  lpi_tag_t             s1_tg_new, s1_tg_old;
  logic                 s1_hold, s1_vld;
  logic                 hold_d;

  always_comb hold_d = err_zero & prev_tag_q.zero;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      prev_log_q <= '0;
      prev_tag_q <= '{neg: 1'b0, zero: 1'b1};
      s1_p_new   <= '0;
      s1_p_old   <= '0;
      s1_tg_new  <= '{neg: 1'b0, zero: 1'b1};
      s1_tg_old  <= '{neg: 1'b0, zero: 1'b1};
      s1_hold    <= 1'b0;
      s1_vld     <= 1'b0;
    end else begin
      s1_vld <= sample_tick;
      if (sample_tick) begin
        s1_p_new   <= p_new;
        s1_p_old   <= p_old;
        s1_tg_new  <= tg_new;
        s1_tg_old  <= tg_old;
        s1_hold    <= hold_d;
        prev_log_q <= err_log;
        prev_tag_q <= cur_tag;
      end
    end
  end

  // Antilog of both products
  logic signed [TW-1:0] t_new_d, t_old_d;

  lpi_antilog #(.PW(PW), .FRAC_W(FRAC_W), .MANT_W(MANT_W), .ACC_FRAC(ACC_FRAC),
                .SHIFT_CAP(SHIFT_CAP), .TW(TW)) u_alog_new (
    .prod_log(s1_p_new), .prod_tag(s1_tg_new), .term(t_new_d));
  lpi_antilog #(.PW(PW), .FRAC_W(FRAC_W), .MANT_W(MANT_W), .ACC_FRAC(ACC_FRAC),
                .SHIFT_CAP(SHIFT_CAP), .TW(TW)) u_alog_old (
    .prod_log(s1_p_old), .prod_tag(s1_tg_old), .term(t_old_d));

  // Stage 2 registers
  logic signed [TW-1:0] s2_t_new, s2_t_old;
  logic                 s2_hold, s2_vld;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      s2_t_new <= '0;
      s2_t_old <= '0;
      s2_hold  <= 1'b0;
      s2_vld   <= 1'b0;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_t_new <= t_new_d;
        s2_t_old <= t_old_d;
        s2_hold  <= s1_hold;
      end
    end
  end

  // Stage 3: accumulate, clamp, output
  lpi_accum #(.TW(TW), .ACC_FRAC(ACC_FRAC), .DUTY_W(DUTY_W)) u_acc (
    .clk(clk), .rst_q_n(rst_q_n), .upd_en(s2_vld), .hold(s2_hold),
    .t_new(s2_t_new), .t_old(s2_t_old), .duty(duty), .out_valid(out_valid));
endmodule

// File: rtl/log_pi_core_chk.sv
module log_pi_core_chk #(
  parameter int DUTY_W = 12
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              sample_tick,
  input logic              err_zero,
  input logic [DUTY_W-1:0] duty,
  input logic              out_valid
);
  logic tk1, tk2, tk3;
  logic zl, hz1, hz2, hz3;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      tk1 <= 1'b0; tk2 <= 1'b0; tk3 <= 1'b0;
      zl  <= 1'b1;
      hz1 <= 1'b0; hz2 <= 1'b0; hz3 <= 1'b0;
    end else begin
      tk1 <= sample_tick; tk2 <= tk1; tk3 <= tk2;
      hz1 <= sample_tick & err_zero & zl;
      hz2 <= hz1; hz3 <= hz2;
      if (sample_tick) zl <= err_zero;
    end
  end

  always @(posedge clk) begin
    if (!rst_q_n) begin
      AST_RESET_QUIET: assert (duty == '0 && !out_valid); // R1
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_valid == tk3); // R2

  AST_DUTY_ONLY_ON_VALID: assert property (@(posedge clk) disable iff (!rst_q_n)
    !out_valid |-> $stable(duty)); // R4

  AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && hz3) |-> $stable(duty)); // R8
endmodule

bind log_pi_core log_pi_core_chk #(.DUTY_W(DUTY_W)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .sample_tick(sample_tick),
  .err_zero(err_zero), .duty(duty), .out_valid(out_valid));

// File: tb/log_pi_core_test.sv
module log_pi_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_tick = 1'b0;
  logic        err_neg = 1'b0;
  logic [11:0] err_log = '0;
  logic        err_zero = 1'b0;
  logic [11:0] duty;
  logic        out_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #10 clk = ~clk;

  log_pi_core uut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .err_neg(err_neg),
    .err_log(err_log), .err_zero(err_zero), .duty(duty), .out_valid(out_valid));

  // Reference model
  longint m_acc = 0;
  int     m_prev_log = 0;
  bit     m_prev_neg = 0;
  bit     m_prev_zero = 1;
  int     edge_n = 0;
  int     due_q[$];
  int     val_q[$];
  int     exp_duty = 0;
  bit     exp_valid = 0;

  function automatic longint term_of(int lg, int gain, bit neg, bit zero);
    int L, E, f, s;
    longint mant, mag;
    if (zero) return 0;
    L = lg + gain;
    E = L >>> 6;
    f = L & 63;
    mant = longint'($rtoi($pow(2.0, real'(f) / 64.0) * 4096.0 + 0.5));
    s = E - 4;
    if (s > 20) s = 20;
    if (s >= 0) mag = mant << s;
    else        mag = mant >> (-s);
    return neg ? -mag : mag;
  endfunction

  always @(posedge clk) begin
    edge_n++;
    exp_valid = 0;
    if (due_q.size() > 0 && due_q[0] == edge_n) begin
      exp_valid = 1;
      exp_duty  = val_q[0];
      void'(due_q.pop_front());
      void'(val_q.pop_front());
    end
    if (sample_tick && rst_n) begin
      longint nxt;
      int     lg;
      lg = int'($signed(err_log));
      if (!(err_zero && m_prev_zero)) begin
        nxt = m_acc + term_of(lg, -400, err_neg, err_zero)
                    - term_of(m_prev_log, -401, m_prev_neg, m_prev_zero);
        if (nxt < 0) nxt = 0;
        if (nxt > 64'd1048575) nxt = 1048575;
        m_acc = nxt;
      end
      m_prev_log  = lg;
      m_prev_neg  = err_neg;
      m_prev_zero = err_zero;
      due_q.push_back(edge_n + 2);
      val_q.push_back(int'(m_acc >>> 8));
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      checks++;
      if (out_valid !== exp_valid) begin
        errors++;
        $display("FAIL R2 out_valid at edge %0d: actual %0b expected %0b", edge_n, out_valid, exp_valid);
      end
      checks++;
      if (duty !== 12'(exp_duty)) begin
        errors++;
        $display("FAIL R4 duty at edge %0d: actual %0d expected %0d", edge_n, duty, exp_duty);
      end
    end
  end

  task automatic check_val(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic do_tick(bit neg, int lg, bit zero);
    @(negedge clk);
    err_neg = neg; err_log = 12'(lg); err_zero = zero; sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    int d_before;
    seed = 12345;
    repeat (3) @(negedge clk);
    check_val("R1 duty in reset", int'(duty), 0);
    check_val("R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    cmp_on = 1;
    check_val("R1 duty after reset", int'(duty), 0);

    // R3: log 400 + (-400) = 0 -> 4096 >> 4 = 256 -> duty 1; previous zero after reset (R1)
    do_tick(0, 400, 0);
    check_val("R3 unit product duty", int'(duty), 1);
    // R4/R9: 256 + 512 - 253 = 515 -> duty 2
    do_tick(0, 464, 0);
    check_val("R4 R9 incremental update", int'(duty), 2);
    // R7: zero input, pending delayed term 506 still subtracted -> 9 -> duty 0
    do_tick(0, 0, 1);
    check_val("R7 zero finishes delayed term", int'(duty), 0);
    // R8: second zero holds
    d_before = int'(duty);
    do_tick(0, 0, 1);
    check_val("R8 hold on repeated zero", int'(duty), d_before);
    // R6: very large error saturates high (shift capped at 20)
    do_tick(0, 1984, 0);
    check_val("R6 saturate high", int'(duty), 4095);
    do_tick(0, 1984, 0);
    check_val("R6 stays at top", int'(duty), 4095);
    // R8 with nonzero output: zero then zero
    do_tick(0, 0, 1);
    d_before = int'(duty);
    do_tick(0, 0, 1);
    check_val("R8 hold keeps output", int'(duty), d_before);
    // R5: large negative error saturates low
    do_tick(0, 1984, 0);
    do_tick(1, 1984, 0);
    check_val("R5 saturate low", int'(duty), 0);

    // Mixed pattern, ticks spaced 1..4 cycles apart, model compared every clock
    for (int i = 0; i < 300; i++) begin
      int gap;
      seed = seed * 1103515245 + 12345;
      @(negedge clk);
      err_neg     = seed[20];
      err_log     = 12'(((seed >>> 8) & 1023) - 200);
      err_zero    = (seed[14:12] == 3'd0);
      sample_tick = 1'b1;
      gap = (seed >>> 24) & 3;
      @(negedge clk);
      sample_tick = 1'b0;
      repeat (gap) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    check_val("R2 queue drained", due_q.size(), 0);
    finish_run();
  end
endmodule